// File: doc/BRIEF.md
# Peripheral I/O Ports with Interval Timer

This block sits on a simple processor bus and provides two 8-bit bidirectional ports and an 8-bit interval timer. Each port has an output latch and a direction register. Pins whose direction bit is 1 drive the latch, and the other pins float. Floating pins are modelled as separate output and output-enable vectors. A read of a port data register mixes latch and pin values bit by bit.

The timer is loaded with an 8-bit count and a prescale choice of 1, 8, 64 or 1024 clocks per step. When the prescaled count runs out, the timer sets a flag in bit 7 of the status register. It then keeps stepping once per clock from 0xFF down to 0, and reads back without the prescale. Reading the timer value also reloads the interrupt enable from an address bit. Reading the status clears the flag. The active-low interrupt output is driven by the flag gated with the enable.

Bus accesses are sampled on the rising clock edge. Read data is registered and appears one clock after the read strobe.

Top module: `io_port_timer`

## Requirements
- R1: After synchronous reset, `rdata` is 0x00 and `irq_n` is 1. Both latches and both direction registers are 0, so `pa_out`, `pa_oe`, `pb_out` and `pb_oe` are 0. The timer is idle.
- R2: A write with `addr[2]`=0 goes to a port register selected by `addr[1:0]`: 0 is A data, 1 is A direction, 2 is B data, 3 is B direction. `*_out` shows the data latch and `*_oe` shows the direction register.
- R3: A port data read returns the latch bit where the direction bit is 1 and the input pin where it is 0. A direction register reads back as written.
- R4: A write with `addr[2]`=1 loads the 8-bit count and starts counting. It takes the prescale from `addr[1:0]` (0 is divide by 1, 1 is 8, 2 is 64, 3 is 1024) and the interrupt enable from `addr[3]`. It also clears the timer flag.
- R5: While counting, the internal remaining-clock count starts at count×divisor and drops by one each clock. A timer read (`addr[2]`=1, `addr[0]`=0) returns that count divided by the divisor, rounded down.
- R6: On the clock after the remaining count has reached 0, the flag is set and the post-count phase starts at 0xFF. In this phase the value drops by one per clock, stops at 0, and reads back undivided.
- R7: A status read (`addr[2]`=1, `addr[0]`=1) returns the flag in bit 7 with bits 6:0 zero, and clears the flag. If an expiry happens on the same edge, the flag stays set.
- R8: A timer read loads the interrupt enable from `addr[3]`. A timer read while idle returns 0x00.
- R9: `irq_n` is 0 exactly when the timer flag and the interrupt enable are both 1.
- R10: `rdata` changes only on the clock edge after a read with `cs`=1 and holds otherwise. Strobes with `cs`=0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A drive value |
| pa_oe | output | 8 | Port A drive enable per bit |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B drive value |
| pb_oe | output | 8 | Port B drive enable per bit |

## Verification
The hardest case to reach from the ports is a status read that lands on the same edge where the counting phase expires. In that case the flag must survive and the interrupt must stay asserted. The stimulus loads a divide-by-1 count of 4 and then waits a fixed number of cycles, so that the status read is sampled on exactly the expiry edge. Long divide-by-1024 runs and waits of more than 255 cycles in post-count cover the largest prescale and the stop at zero.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {TM_IDLE = 2'd0, TM_RUN = 2'd1, TM_POST = 2'd2} tm_state_t;

  localparam int SEL_W  = 2;
  localparam int SH_MAX = 10;
  localparam int SH_W   = $clog2(SH_MAX + 1);

  function automatic logic [SH_W-1:0] sel_to_shift(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    return SH_W'(0);
      2'd1:    return SH_W'(3);
      2'd2:    return SH_W'(6);
      default: return SH_W'(SH_MAX);
    endcase
  endfunction
endpackage

// File: rtl/pio_port.sv
module pio_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_latch,
  input  logic          wr_dir,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] latch_q,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] merged
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_latch) latch_q <= wdata;
      if (wr_dir)   dir_q   <= wdata;
    end
  end

  always_comb merged = (latch_q & dir_q) | (pin_in & ~dir_q);

  // R2
  latch_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_latch |=> (latch_q == $past(wdata)));
endmodule

// File: rtl/pio_interval_timer.sv
module pio_interval_timer
  import pio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [DW-1:0]    ld_val,
  input  logic             ld_ien,
  input  logic             rd_cnt,
  input  logic             rd_ien,
  input  logic             rd_flag,
  output logic [DW-1:0]    tval,
  output logic             flag_q,
  output logic             ien_q,
  output logic             expire
);
  localparam int TW = DW + SH_MAX;

  tm_state_t       state_q;
  logic [TW-1:0]   ticks_q;
  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] ld_sh;

  always_comb ld_sh  = sel_to_shift(ld_sel);
  always_comb expire = (state_q == TM_RUN) && (ticks_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TM_IDLE;
      ticks_q <= '0;
      sh_q    <= '0;
      flag_q  <= 1'b0;
      ien_q   <= 1'b0;
    end else if (ld) begin
      state_q <= TM_RUN;
      ticks_q <= TW'(ld_val) << ld_sh;
      sh_q    <= ld_sh;
      flag_q  <= 1'b0;
      ien_q   <= ld_ien;
    end else begin
      case (state_q)
        TM_RUN: begin
          if (expire) begin
            state_q <= TM_POST;
            ticks_q <= TW'({DW{1'b1}});
          end else begin
            ticks_q <= ticks_q - 1'b1;
          end
        end
        TM_POST: if (ticks_q != '0) ticks_q <= ticks_q - 1'b1;
        default: ;
      endcase
      if (expire)       flag_q <= 1'b1;
      else if (rd_flag) flag_q <= 1'b0;
      if (rd_cnt) ien_q <= rd_ien;
    end
  end

  always_comb begin
    case (state_q)
      TM_RUN:  tval = DW'(ticks_q >> sh_q);
      TM_POST: tval = ticks_q[DW-1:0];
      default: tval = '0;
    endcase
  end

  // R4
  load_run_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> (state_q == TM_RUN && !flag_q));
  // R6
  expire_post_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !ld) |=> (state_q == TM_POST && flag_q && ticks_q == TW'({DW{1'b1}})));
  // R6
  post_nonrise_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == TM_POST && !ld) |=> (state_q == TM_POST && ticks_q <= $past(ticks_q)));
  // R5
  run_nonrise_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == TM_RUN && !ld && !expire) |=> (tval <= $past(tval)));
endmodule

// File: rtl/io_port_timer.sv
module io_port_timer
  import pio_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_n,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe
);
  localparam int NPORT = 2;

  logic acc_rd, acc_wr, io_sel;
  logic [DW-1:0] pin_v   [NPORT];
  logic [DW-1:0] latch_v [NPORT];
  logic [DW-1:0] dir_v   [NPORT];
  logic [DW-1:0] merge_v [NPORT];

  always_comb begin
    acc_rd = cs & rd;
    acc_wr = cs & wr;
    io_sel = ~addr[2];
  end

  assign pin_v[0] = pa_in;
  assign pin_v[1] = pb_in;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic hit;
    assign hit = acc_wr & io_sel & (addr[1] == 1'(i));
    pio_port #(.DW(DW)) u_port (
      .clk      (clk),
      .rst      (rst),
      .wr_latch (hit & ~addr[0]),
      .wr_dir   (hit &  addr[0]),
      .wdata    (wdata),
      .pin_in   (pin_v[i]),
      .latch_q  (latch_v[i]),
      .dir_q    (dir_v[i]),
      .merged   (merge_v[i])
    );
  end

  assign pa_out = latch_v[0];
  assign pa_oe  = dir_v[0];
  assign pb_out = latch_v[1];
  assign pb_oe  = dir_v[1];

  logic [DW-1:0] t_val;
  logic t_flag, t_ien, t_expire;
  logic t_rd_cnt, t_rd_flag;

  always_comb begin
    t_rd_cnt  = acc_rd & addr[2] & ~addr[0];
    t_rd_flag = acc_rd & addr[2] &  addr[0];
  end

  pio_interval_timer #(.DW(DW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .ld      (acc_wr & addr[2]),
    .ld_sel  (addr[1:0]),
    .ld_val  (wdata),
    .ld_ien  (addr[3]),
    .rd_cnt  (t_rd_cnt),
    .rd_ien  (addr[3]),
    .rd_flag (t_rd_flag),
    .tval    (t_val),
    .flag_q  (t_flag),
    .ien_q   (t_ien),
    .expire  (t_expire)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    if (io_sel) begin
      rd_mux = addr[0] ? dir_v[addr[1]] : merge_v[addr[1]];
    end else if (addr[0]) begin
      rd_mux = {t_flag, {(DW-1){1'b0}}};
    end else begin
      rd_mux = t_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (acc_rd) rdata <= rd_mux;
  end

  assign irq_n = ~(t_flag & t_ien);

  // R7
  flag_release_chk: assert property (@(posedge clk) disable iff (rst)
    (t_rd_flag && !t_expire && !acc_wr) |=> irq_n);
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> $stable(rdata));
endmodule

// File: tb/tb_io_port_timer.sv
module tb_io_port_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 0, rd = 0, wr = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, pa_in = '0, pb_in = '0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe;
  logic irq_n;

  io_port_timer dut (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_n(irq_n),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  string cur_tag = "R1";
  bit comparing = 0;

  // reference model state
  logic [7:0] m_la, m_da, m_lb, m_db, m_rdata;
  int m_state, m_rem, m_div, m_post;
  bit m_flag, m_en;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_la = 0; m_da = 0; m_lb = 0; m_db = 0; m_rdata = 0;
      m_state = 0; m_rem = 0; m_div = 1; m_post = 0; m_flag = 0; m_en = 0;
    end else begin
      logic [7:0] rv;
      bit exp_now;
      rv = m_rdata;
      if (cs && rd) begin
        if (!addr[2]) begin
          case (addr[1:0])
            2'd0: rv = (m_la & m_da) | (pa_in & ~m_da);
            2'd1: rv = m_da;
            2'd2: rv = (m_lb & m_db) | (pb_in & ~m_db);
            default: rv = m_db;
          endcase
        end else if (addr[0]) rv = m_flag ? 8'h80 : 8'h00;
        else if (m_state == 1) rv = 8'(m_rem / m_div);
        else if (m_state == 2) rv = 8'(m_post);
        else rv = 8'h00;
      end
      exp_now = (m_state == 1 && m_rem == 0);
      if (cs && wr && addr[2]) begin
        case (addr[1:0])
          2'd0: m_div = 1;
          2'd1: m_div = 8;
          2'd2: m_div = 64;
          default: m_div = 1024;
        endcase
        m_state = 1; m_rem = int'(wdata) * m_div; m_en = addr[3]; m_flag = 0;
      end else begin
        if (m_state == 1) begin
          if (m_rem == 0) begin m_state = 2; m_post = 255; m_flag = 1; end
          else m_rem = m_rem - 1;
        end else if (m_state == 2 && m_post > 0) m_post = m_post - 1;
        if (cs && rd && addr[2] && addr[0] && !exp_now) m_flag = 0;
        if (cs && rd && addr[2] && !addr[0]) m_en = addr[3];
      end
      if (cs && wr && !addr[2]) begin
        case (addr[1:0])
          2'd0: m_la = wdata;
          2'd1: m_da = wdata;
          2'd2: m_lb = wdata;
          default: m_db = wdata;
        endcase
      end
      m_rdata = rv;
    end
  end

  always @(negedge clk) begin
    if (comparing && !rst) begin
      check(rdata == m_rdata, cur_tag, rdata, m_rdata);
      check(irq_n == !(m_flag && m_en), "R9 irq_n", irq_n, !(m_flag && m_en));
      check({pa_out, pa_oe, pb_out, pb_oe} == {m_la, m_da, m_lb, m_db}, "R2 port outputs",
            {pa_out, pa_oe, pb_out, pb_oe}, {m_la, m_da, m_lb, m_db});
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d, input bit sel = 1);
    @(negedge clk); cs = sel; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input bit sel = 1);
    @(negedge clk); cs = sel; rd = 1; addr = a;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(4);
    @(negedge clk); rst = 0;
    // R1 reset state
    check(rdata == 8'h00, "R1 rdata", rdata, 0);
    check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
    check({pa_out, pa_oe, pb_out, pb_oe} == 32'h0, "R1 ports", {pa_out, pa_oe, pb_out, pb_oe}, 0);
    comparing = 1;
    cur_tag = "R8 idle timer read"; bus_rd(4'b0100);
    check(rdata == 8'h00, "R8 idle read", rdata, 0);

    cur_tag = "R3 port A";
    bus_wr(4'b0001, 8'hF0); bus_wr(4'b0000, 8'h5A);
    pa_in = 8'h33; bus_rd(4'b0000);
    check(rdata == 8'h53, "R3 port A merge", rdata, 8'h53);
    bus_rd(4'b0001);
    cur_tag = "R3 port B";
    bus_wr(4'b0011, 8'h0F); bus_wr(4'b0010, 8'hC3);
    pb_in = 8'hA5; bus_rd(4'b0010);
    check(rdata == 8'hA3, "R3 port B merge", rdata, 8'hA3);
    pb_in = 8'h5A; bus_rd(4'b1010); bus_rd(4'b0011);
    cur_tag = "R10 deselected";
    bus_wr(4'b0001, 8'h0F, 0); bus_rd(4'b0001, 0); idle(2); bus_rd(4'b0001);
    check(rdata == 8'hF0, "R10 cs ignored", rdata, 8'hF0);

    cur_tag = "R4 R5 divide by 1";
    bus_wr(4'b1100, 8'd10);
    bus_rd(4'b1100); idle(3); bus_rd(4'b1100);
    cur_tag = "R6 expiry";
    idle(10); bus_rd(4'b1101); bus_rd(4'b1100); idle(5); bus_rd(4'b1100);
    cur_tag = "R7 flag clear";
    bus_wr(4'b1100, 8'd3); idle(8); bus_rd(4'b1101);
    check(irq_n == 1'b1, "R7 irq released", irq_n, 1); bus_rd(4'b1101);

    cur_tag = "R7 same-edge collision";
    bus_wr(4'b1100, 8'd4); idle(3); bus_rd(4'b1101);
    check(irq_n == 1'b0, "R7 collision keeps flag", irq_n, 0);
    bus_rd(4'b1101);

    cur_tag = "R8 R9 enable via read";
    bus_wr(4'b0101, 8'd5);
    idle(7); bus_rd(4'b0100); idle(40);
    check(irq_n == 1'b1, "R9 disabled flag", irq_n, 1);
    bus_rd(4'b1100);
    check(irq_n == 1'b0, "R8 enable loaded", irq_n, 0);
    bus_rd(4'b0100); bus_rd(4'b1101);

    cur_tag = "R5 divide by 64";
    bus_wr(4'b1110, 8'd2); idle(30); bus_rd(4'b1110); idle(100); bus_rd(4'b1110);
    cur_tag = "R5 divide by 1024";
    bus_wr(4'b1111, 8'd3); idle(500); bus_rd(4'b1100); idle(1200); bus_rd(4'b1100);
    idle(1400); bus_rd(4'b1100);
    cur_tag = "R6 saturate";
    idle(300); bus_rd(4'b1100);
    check(rdata == 8'h00, "R6 post-count held at 0", rdata, 0);
    bus_rd(4'b1101);

    cur_tag = "R1 reset again";
    bus_wr(4'b1100, 8'd1); idle(4);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    check(irq_n == 1'b1 && rdata == 8'h00, "R1 re-reset", {irq_n, rdata}, 9'h100);
    bus_rd(4'b1100); idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule